// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the device-side serial interface of a NOR flash model. It oversamples the chip select, serial clock, serial data input and hold pins on the system clock and shifts in the 8-bit opcode and the 24-bit address, most significant bit first. It also takes in dummy clocks where the command needs them. Two read commands are supported, a plain read and a fast read with eight dummy clocks. Both return a continuous byte stream from a small computed array that stands in for the flash cells. The block also keeps a write-enable latch, which one opcode sets and another clears.

Downstream logic gets the decoded opcode, the start address and a one-cycle start pulse in the system clock domain. A command that is not recognised, or a frame that ends early, starts nothing. After an unknown opcode the block ignores the rest of the frame. A hold condition pauses the serial transfer and releases the output, but only when it begins while the serial clock is low.

Top module: `sflash_frontend`

## Requirements
- R1: Serial modes 0 and 3 both work: input bits are taken on rising serial clock edges and output bits change on falling edges. In mode 3, the falling edge that comes before the first opcode bit has no effect.
- R2: A frame begins when chip select goes low. The first 8 rising edges carry the opcode, most significant bit first.
- R3: For the read opcodes the next 24 rising edges carry the address, most significant bit first. Address bits 23 to 21 are discarded, and `cmd_addr` reports the lower 21 bits.
- R4: With opcode 0x03, bit 7 of the first data byte is driven after the first falling edge that follows the last address bit. `spi_miso_oe` is high while data is shifted out.
- R5: With opcode 0x0B, 8 dummy rising edges follow the address. Data starts on the falling edge after the eighth dummy edge.
- R6: The read address advances by one after each byte. After 0x1FFFFF it continues at 0x000000 with no gap.
- R7: Any opcode other than 0x03, 0x0B, 0x06 and 0x04 is ignored for the rest of the frame. No start pulse is raised, the write-enable latch keeps its value, and the output stays released until chip select goes high and then low again.
- R8: If chip select rises before the opcode is complete, or before a read address is complete, nothing is started and the write-enable latch keeps its value.
- R9: The write-enable latch is 0 after reset. It is set by opcode 0x06, cleared by opcode 0x04, and changes only together with a start pulse.
- R10: `cmd_start` is high for exactly one system clock per accepted command, with `cmd_opcode` and `cmd_addr` valid. For 0x06 and 0x04 it comes at the end of the opcode, with an address of 0. For reads it comes at the end of the address.
- R11: When chip select rises, including in the middle of a byte, `spi_miso_oe` is low no more than 3 system clocks later.
- R12: A hold condition starts only while chip select is low and the serial clock is low. While it lasts, clock and data edges are ignored and `spi_miso_oe` is low. After release the transfer continues where it stopped. A hold pulse that starts and ends while the clock is high has no effect.
- R13: The byte at 21-bit address a is ((a mod 64)·37 + 0x5A) mod 256, XOR a[20:13].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data into the block |
| spi_hold_n | input | 1 | Hold request, active low |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Output enable for spi_miso; low means high impedance |
| wel | output | 1 | Write-enable latch |
| cmd_start | output | 1 | One-cycle pulse for an accepted command |
| cmd_opcode | output | 8 | Opcode of the last accepted command |
| cmd_addr | output | 21 | Start address of the last accepted command |

## Verification
The assertions assume that the serial pins change slowly compared with the system clock. Each serial clock level must last several system clocks, so that the synchroniser never misses an edge and start pulses are spaced far apart. They also assume that chip select moves only while the serial clock is at its idle level. The bench drives each serial clock half-period as 8 system clocks and changes every pin on the falling system edge. It toggles hold only at points with a stable clock level, and it mixes random read addresses, lengths and modes with directed frames: the wrap point, the discarded upper address bits, lockout, truncation, mid-byte deselect and both kinds of hold.

// File: rtl/sflash_pkg.sv
package sflash_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_OPC, ST_ADDR, ST_DUMMY, ST_DATA, ST_DONE, ST_LOCK
   } fe_state_e;

   localparam logic [7:0] OP_READ  = 8'h03;
   localparam logic [7:0] OP_FREAD = 8'h0B;
   localparam logic [7:0] OP_WREN  = 8'h06;
   localparam logic [7:0] OP_WRDI  = 8'h04;
endpackage

// File: rtl/sflash_pin_sync.sv
module sflash_pin_sync #(
   parameter int          STAGES  = 2,
   parameter int          W       = 4,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("sflash_pin_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RST_VAL;
      else        chain[0] <= din;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/sflash_link.sv
module sflash_link (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_s,
   input  logic sck_s,
   input  logic hold_n_s,
   output logic frame_act,
   output logic frame_start,
   output logic rise_ev,
   output logic fall_ev,
   output logic hold_act
);
   logic sck_q, cs_q, hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q  <= 1'b0;
         cs_q   <= 1'b1;
         hold_q <= 1'b0;
      end else begin
         sck_q  <= sck_s;
         cs_q   <= cs_n_s;
         // a hold begins only with the clock low; it then lasts until release
         hold_q <= !cs_n_s && !hold_n_s && (hold_q || !sck_s);
      end
   end

   assign frame_act   = !cs_n_s;
   assign frame_start = !cs_n_s && cs_q;
   assign hold_act    = hold_q;
   assign rise_ev     = frame_act && !hold_q && sck_s && !sck_q;
   assign fall_ev     = frame_act && !hold_q && !sck_s && sck_q;
endmodule

// File: rtl/sflash_cmd_fsm.sv
module sflash_cmd_fsm
   import sflash_pkg::*;
#(
   parameter int ADDR_W    = 21,
   parameter int ADDR_BITS = 24,
   parameter int DUMMY_CYC = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_act,
   input  logic              frame_start,
   input  logic              rise_ev,
   input  logic              mosi_s,
   output fe_state_e         state,
   output logic              cmd_start,
   output logic [7:0]        cmd_opcode,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic              wel
);
   localparam int CNT_W = $clog2(ADDR_BITS + 1);

   generate
      if (ADDR_W < 9 || ADDR_W > ADDR_BITS) begin : g_bad_addr
         $error("sflash_cmd_fsm: ADDR_W out of range");
      end
      if (DUMMY_CYC < 1 || DUMMY_CYC > ADDR_BITS) begin : g_bad_dummy
         $error("sflash_cmd_fsm: DUMMY_CYC out of range");
      end
   endgenerate

   logic [ADDR_W-2:0] sh;
   logic [CNT_W-1:0]  cnt;
   logic [7:0]        op_next;
   logic [ADDR_W-1:0] addr_next;

   assign op_next   = {sh[6:0], mosi_s};
   assign addr_next = {sh, mosi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         sh         <= '0;
         cnt        <= '0;
         cmd_start  <= 1'b0;
         cmd_opcode <= '0;
         cmd_addr   <= '0;
         wel        <= 1'b0;
      end else begin
         cmd_start <= 1'b0;
         if (!frame_act) begin
            state <= ST_IDLE;
         end else if (frame_start) begin
            state <= ST_OPC;
            cnt   <= '0;
         end else if (rise_ev) begin
            case (state)
               ST_OPC: begin
                  sh  <= addr_next[ADDR_W-2:0];
                  cnt <= cnt + 1'b1;
                  if (cnt == CNT_W'(7)) begin
                     cnt <= '0;
                     unique case (op_next)
                        OP_READ, OP_FREAD: begin
                           cmd_opcode <= op_next;
                           state      <= ST_ADDR;
                        end
                        OP_WREN, OP_WRDI: begin
                           cmd_opcode <= op_next;
                           cmd_addr   <= '0;
                           cmd_start  <= 1'b1;
                           wel        <= (op_next == OP_WREN);
                           state      <= ST_DONE;
                        end
                        default: state <= ST_LOCK;
                     endcase
                  end
               end
               ST_ADDR: begin
                  sh  <= addr_next[ADDR_W-2:0];
                  cnt <= cnt + 1'b1;
                  if (cnt == CNT_W'(ADDR_BITS - 1)) begin
                     cnt       <= '0;
                     cmd_addr  <= addr_next;
                     cmd_start <= 1'b1;
                     state     <= (cmd_opcode == OP_FREAD) ? ST_DUMMY : ST_DATA;
                  end
               end
               ST_DUMMY: begin
                  cnt <= cnt + 1'b1;
                  if (cnt == CNT_W'(DUMMY_CYC - 1)) state <= ST_DATA;
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/sflash_rd_array.sv
module sflash_rd_array #(
   parameter int         ADDR_W  = 21,
   parameter int         DEPTH   = 64,
   parameter logic [7:0] PAT_MUL = 8'd37,
   parameter logic [7:0] PAT_ADD = 8'h5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_act,
   input  logic              hold_act,
   input  logic              data_phase,
   input  logic              fall_ev,
   input  logic              load,
   input  logic [ADDR_W-1:0] start_addr,
   output logic              miso,
   output logic              miso_oe
);
   localparam int IDX_W = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || DEPTH != (1 << IDX_W)) begin : g_bad_depth
         $error("sflash_rd_array: DEPTH must be a power of two");
      end
      if (ADDR_W < IDX_W || ADDR_W < 8) begin : g_bad_width
         $error("sflash_rd_array: ADDR_W too small for DEPTH");
      end
   endgenerate

   logic [7:0]        cells [DEPTH];
   logic [ADDR_W-1:0] raddr;
   logic [2:0]        obit;
   logic [7:0]        oshift;
   logic              data_on;
   logic [7:0]        rd_byte;

   assign rd_byte = cells[raddr[IDX_W-1:0]] ^ raddr[ADDR_W-1 -: 8];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= 8'(i) * PAT_MUL + PAT_ADD;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raddr   <= '0;
         obit    <= '0;
         oshift  <= '0;
         miso    <= 1'b0;
         data_on <= 1'b0;
      end else if (!frame_act) begin
         data_on <= 1'b0;
      end else if (load) begin
         raddr   <= start_addr;
         obit    <= '0;
         data_on <= 1'b0;
      end else if (data_phase && fall_ev) begin
         data_on <= 1'b1;
         obit    <= obit + 1'b1;
         if (obit == 3'd0) begin
            miso   <= rd_byte[7];
            oshift <= {rd_byte[6:0], 1'b0};
            raddr  <= raddr + 1'b1;
         end else begin
            miso   <= oshift[7];
            oshift <= {oshift[6:0], 1'b0};
         end
      end
   end

   assign miso_oe = frame_act && data_on && !hold_act;
endmodule

// File: rtl/sflash_frontend.sv
module sflash_frontend
   import sflash_pkg::*;
#(
   parameter int ADDR_W      = 21,
   parameter int ADDR_BITS   = 24,
   parameter int DUMMY_CYC   = 8,
   parameter int DEPTH       = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_cs_n,
   input  logic              spi_sck,
   input  logic              spi_mosi,
   input  logic              spi_hold_n,
   output logic              spi_miso,
   output logic              spi_miso_oe,
   output logic              wel,
   output logic              cmd_start,
   output logic [7:0]        cmd_opcode,
   output logic [ADDR_W-1:0] cmd_addr
);
   logic [3:0] pins_s;
   logic       frame_act, frame_start, rise_ev, fall_ev, hold_act, rd_load;
   fe_state_e  fsm_state;

   sflash_pin_sync #(.STAGES(SYNC_STAGES), .W(4), .RST_VAL(4'b1001)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({spi_cs_n, spi_sck, spi_mosi, spi_hold_n}),
      .dout (pins_s)
   );

   sflash_link u_link (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n_s     (pins_s[3]),
      .sck_s      (pins_s[2]),
      .hold_n_s   (pins_s[0]),
      .frame_act  (frame_act),
      .frame_start(frame_start),
      .rise_ev    (rise_ev),
      .fall_ev    (fall_ev),
      .hold_act   (hold_act)
   );

   sflash_cmd_fsm #(.ADDR_W(ADDR_W), .ADDR_BITS(ADDR_BITS), .DUMMY_CYC(DUMMY_CYC)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_act  (frame_act),
      .frame_start(frame_start),
      .rise_ev    (rise_ev),
      .mosi_s     (pins_s[1]),
      .state      (fsm_state),
      .cmd_start  (cmd_start),
      .cmd_opcode (cmd_opcode),
      .cmd_addr   (cmd_addr),
      .wel        (wel)
   );

   assign rd_load = cmd_start && (cmd_opcode == OP_READ || cmd_opcode == OP_FREAD);

   sflash_rd_array #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_act (frame_act),
      .hold_act  (hold_act),
      .data_phase(fsm_state == ST_DATA),
      .fall_ev   (fall_ev),
      .load      (rd_load),
      .start_addr(cmd_addr),
      .miso      (spi_miso),
      .miso_oe   (spi_miso_oe)
   );
endmodule

// File: rtl/sflash_frontend_chk.sv
module sflash_frontend_chk
   import sflash_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      spi_cs_n,
   input logic      spi_miso_oe,
   input logic      wel,
   input logic      cmd_start,
   input logic [7:0] cmd_opcode,
   input fe_state_e fsm_state,
   input logic      hold_act
);
   p_start_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |=> !cmd_start);

   p_start_opcode_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |-> (cmd_opcode == OP_READ || cmd_opcode == OP_FREAD ||
                     cmd_opcode == OP_WREN || cmd_opcode == OP_WRDI));

   p_wel_with_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wel) |-> cmd_start);

   p_lock_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_state == ST_LOCK) |-> (!cmd_start && !spi_miso_oe));

   p_deselect_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_cs_n && $past(spi_cs_n, 1) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
      |-> !spi_miso_oe);

   p_hold_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      hold_act |-> !spi_miso_oe);
endmodule

bind sflash_frontend sflash_frontend_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .spi_cs_n   (spi_cs_n),
   .spi_miso_oe(spi_miso_oe),
   .wel        (wel),
   .cmd_start  (cmd_start),
   .cmd_opcode (cmd_opcode),
   .fsm_state  (fsm_state),
   .hold_act   (hold_act)
);

// File: tb/sflash_frontend_tb.sv
`timescale 1ns/1ps
module sflash_frontend_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1;
   logic        miso, miso_oe, wel, cmd_start;
   logic [7:0]  cmd_opcode;
   logic [20:0] cmd_addr;

   int n_tests = 0, n_fail = 0, n_start = 0;
   logic [7:0]  last_op = '0;
   logic [20:0] last_addr = '0;
   logic        mode3 = 1'b0;
   logic        done = 1'b0;

   always #2.5 clk = ~clk;

   sflash_frontend u_dut (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
      .spi_hold_n(hold_n), .spi_miso(miso), .spi_miso_oe(miso_oe), .wel(wel),
      .cmd_start(cmd_start), .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr)
   );

   always @(negedge clk) begin
      if (cmd_start) begin
         n_start   <= n_start + 1;
         last_op   <= cmd_opcode;
         last_addr <= cmd_addr;
      end
   end

   function automatic logic [7:0] exp_byte(input logic [20:0] a);
      logic [7:0] b;
      b = 8'(a[5:0]) * 8'd37 + 8'h5A;
      return b ^ a[20:13];
   endfunction

   task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic half();
      repeat (8) @(negedge clk);
   endtask

   task automatic cs_begin();
      @(negedge clk);
      sck = mode3;
      half();
      cs_n = 1'b0;
      half();
   endtask

   task automatic cs_end();
      if (!mode3) sck = 1'b0;
      half();
      cs_n = 1'b1;
      half();
      sck = mode3;
      half();
   endtask

   task automatic xbit(input logic b, output logic r);
      sck  = 1'b0;
      mosi = b;
      half();
      r   = miso;
      sck = 1'b1;
      half();
   endtask

   task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
      for (int b = 7; b >= 0; b--) xbit(tx[b], rx[b]);
   endtask

   // hk: 0 none, 1 hold with clock low, 2 hold pulse with clock high
   task automatic do_read(input logic [7:0] op, input logic [23:0] a, input int n,
                          input int hk, input int hat);
      logic [7:0]  rx, dmy;
      logic        r;
      logic [20:0] ea;
      int          s0;
      s0 = n_start;
      cs_begin();
      xbyte(op, dmy);
      xbyte(a[23:16], dmy);
      xbyte(a[15:8], dmy);
      xbyte(a[7:0], dmy);
      chk(n_start == s0 + 1, "R10 start pulse count", n_start, s0 + 1);
      chk(last_addr == a[20:0], "R3 reported address", last_addr, a[20:0]);
      chk(last_op == op, "R10 reported opcode", last_op, op);
      if (op == 8'h0B) xbyte(8'($urandom), dmy);
      for (int i = 0; i < n; i++) begin
         for (int b = 7; b >= 0; b--) begin
            if (hk != 0 && i * 8 + (7 - b) == hat) begin
               if (hk == 1) begin
                  sck = 1'b0;
                  half();
                  hold_n = 1'b0;
                  half();
                  chk(miso_oe == 1'b0, "R12 output released in hold", miso_oe, 0);
                  for (int k = 0; k < 3; k++) begin
                     sck = 1'b1; mosi = 1'($urandom); half();
                     sck = 1'b0; half();
                  end
                  hold_n = 1'b1;
                  half();
                  chk(miso_oe == 1'b1, "R12 output back after hold", miso_oe, 1);
               end else begin
                  hold_n = 1'b0;
                  repeat (3) @(negedge clk);
                  hold_n = 1'b1;
                  repeat (3) @(negedge clk);
                  chk(miso_oe == 1'b1, "R12 high-clock hold ignored", miso_oe, 1);
               end
            end
            xbit(1'b0, r);
            rx[b] = r;
         end
         ea = 21'(a[20:0] + 21'(i));
         chk(rx == exp_byte(ea), (op == 8'h0B) ? "R5 R6 R13 fast read byte" : "R4 R6 R13 read byte",
             rx, exp_byte(ea));
      end
      chk(miso_oe == 1'b1, "R4 output enabled in data", miso_oe, 1);
      cs_end();
      chk(miso_oe == 1'b0, "R11 output off after deselect", miso_oe, 0);
   endtask

   task automatic short_cmd(input logic [7:0] op);
      logic [7:0] dmy;
      cs_begin();
      xbyte(op, dmy);
      cs_end();
   endtask

   initial begin
      logic [7:0] dmy;
      logic       r;
      int         s0;
      void'($urandom(32'h5F1A_0C3D));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(miso_oe == 1'b0, "R11 reset output off", miso_oe, 0);
      chk(wel == 1'b0, "R9 reset latch", wel, 0);
      chk(cmd_start == 1'b0, "R10 reset no pulse", cmd_start, 0);

      // R1 R4 directed reads in both modes
      mode3 = 1'b0; do_read(8'h03, 24'h001234, 3, 0, 0);
      mode3 = 1'b1; do_read(8'h03, 24'h0ABCDE, 3, 0, 0);
      mode3 = 1'b0; do_read(8'h0B, 24'h100040, 2, 0, 0);
      // R6 wrap at top of array
      do_read(8'h03, 24'h1FFFFE, 4, 0, 0);
      mode3 = 1'b1; do_read(8'h0B, 24'h1FFFFF, 2, 0, 0);
      // R3 upper address bits discarded
      mode3 = 1'b0; do_read(8'h03, 24'hE0002A, 2, 0, 0);

      // R9 latch set and clear
      s0 = n_start;
      short_cmd(8'h06);
      chk(wel == 1'b1, "R9 latch set", wel, 1);
      chk(n_start == s0 + 1 && last_addr == 0, "R10 pulse for set", n_start, s0 + 1);

      // R7 unsupported opcode locks out the frame
      s0 = n_start;
      cs_begin();
      xbyte(8'h9F, dmy);
      xbyte(8'h04, dmy);
      xbyte(8'h03, dmy);
      xbyte(8'h00, dmy);
      xbyte(8'h00, dmy);
      xbyte(8'h00, dmy);
      xbyte(8'h00, dmy);
      chk(miso_oe == 1'b0, "R7 output stays off", miso_oe, 0);
      cs_end();
      chk(n_start == s0, "R7 no pulse", n_start, s0);
      chk(wel == 1'b1, "R7 latch kept", wel, 1);

      short_cmd(8'h04);
      chk(wel == 1'b0, "R9 latch cleared", wel, 0);

      // R8 truncated opcode and truncated address
      s0 = n_start;
      cs_begin();
      for (int b = 7; b >= 4; b--) xbit(1'(8'h06 >> b), r);
      cs_end();
      chk(wel == 1'b0 && n_start == s0, "R8 short opcode ignored", {wel, 8'(n_start - s0)}, 0);
      cs_begin();
      xbyte(8'h03, dmy);
      xbyte(8'h00, dmy);
      xbyte(8'h10, dmy);
      cs_end();
      chk(n_start == s0, "R8 short address ignored", n_start, s0);

      // R11 deselect in the middle of a byte
      cs_begin();
      xbyte(8'h03, dmy);
      xbyte(8'h00, dmy); xbyte(8'h00, dmy); xbyte(8'h08, dmy);
      xbyte(8'h00, dmy);
      for (int b = 0; b < 3; b++) xbit(1'b0, r);
      chk(miso_oe == 1'b1, "R4 output on before deselect", miso_oe, 1);
      cs_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(miso_oe == 1'b0, "R11 mid-byte deselect", miso_oe, 0);
      sck = mode3;
      half();

      // R12 hold cases
      do_read(8'h03, 24'h0004F0, 3, 1, 11);
      mode3 = 1'b1; do_read(8'h0B, 24'h1C0007, 2, 1, 4);
      mode3 = 1'b0; do_read(8'h03, 24'h000333, 2, 2, 5);

      // random reads
      for (int t = 0; t < 18; t++) begin
         mode3 = 1'($urandom);
         do_read(($urandom % 2) ? 8'h0B : 8'h03, 24'($urandom), 1 + int'($urandom % 4), 0, 0);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL R2 watchdog: actual=timeout expected=complete");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule